// File: doc/BRIEF.md
# DRAM Burst Read Timing Sequencer

This block produces the clock-accurate beat timing of a four-transfer burst read from main DRAM on a processor bus. One read is in flight at a time. When the sequencer is idle and a request arrives, it captures the memory technology (EDO or fast-page), the bus-speed class (50 MHz or 66 MHz) and a page hit/miss decision. It then raises a one-clock data-ready strobe at each of the four transfer points.

The hit/miss decision comes from one of two places. It can be supplied from outside, or the block can derive it from its own open-row register. That register remembers the row of the last accepted request and holds no valid row after reset. A burst-done pulse coincides with the final data-ready strobe, and the sequencer is ready for a new request on the clock that follows.

Top module: `dram_burst_seq`

## Requirements
- R1: A request (`req_valid` high at a clock edge while `busy` is low) is accepted at that edge, and `busy` is high in the following cycle.
- R2: With `mem_edo`=1 the pattern is 7-2-2-2 on a hit and 10-2-2-2 on a miss, for either value of `bus_fast`. The first number is the count of edges from the accepting edge to the edge that raises the first strobe, and each later number is the count of edges between successive strobes.
- R3: With `mem_edo`=0 and `bus_fast`=1 (66 MHz class) the pattern is 7-4-4-4 on a hit and 10-4-4-4 on a miss.
- R4: With `mem_edo`=0 and `bus_fast`=0 (50 MHz class) the pattern is 6-3-3-3 on a hit and 8-3-3-3 on a miss.
- R5: `data_rdy` is high for exactly one clock per transfer, four times per burst. `burst_done` is high only in the cycle of the fourth strobe, and `busy` is low in that same cycle.
- R6: While `busy` is high, `req_valid` and all configuration and row inputs have no effect: the running burst keeps its timing, and the open row is not changed.
- R7: With `use_tracker`=1 a request is a hit exactly when a valid open row equals `req_row`. Every accepted request, tracked or not, loads `req_row` into the open-row register. `hit_taken` shows the decision of the current burst from the cycle after acceptance.
- R8: After reset no open row is valid, so the first tracked request is a miss even if its row is zero.
- R9: With `use_tracker`=0 the hit decision is `ext_hit` sampled at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst read request |
| req_row | input | ROW_W | Row address of the request |
| use_tracker | input | 1 | 1: decide hit from open-row register; 0: use `ext_hit` |
| ext_hit | input | 1 | External page-hit indication |
| mem_edo | input | 1 | 1: EDO memory; 0: fast-page memory |
| bus_fast | input | 1 | 1: 66 MHz class; 0: 50 MHz class |
| busy | output | 1 | Burst in progress |
| data_rdy | output | 1 | One-clock strobe per completed transfer |
| burst_done | output | 1 | High with the fourth strobe |
| hit_taken | output | 1 | Hit decision of the current or last burst |

## Verification
A corrupted beat counter or countdown shows up at the ports within one gap interval, at most four clocks. It appears as a strobe in the wrong cycle, a fifth strobe, or a burst that ends early with `busy` dropping too soon. A wrong open-row state is visible on the next tracked request: `hit_taken` flips and the first strobe moves by two to three clocks. A latched configuration that a mid-burst request overwrites changes the spacing of the remaining strobes. The bench compares every cycle of every burst, over all memory, speed and hit combinations, against arithmetically predicted strobe positions.

// File: rtl/dram_burst_seq.sv
module dram_burst_seq #(
  parameter int ROW_W         = 8,
  parameter int CNT_W         = 4,
  parameter int BEATS         = 4,
  parameter int EDO_HIT       = 7,
  parameter int EDO_MISS      = 10,
  parameter int EDO_GAP       = 2,
  parameter int FPM_FAST_HIT  = 7,
  parameter int FPM_FAST_MISS = 10,
  parameter int FPM_FAST_GAP  = 4,
  parameter int FPM_SLOW_HIT  = 6,
  parameter int FPM_SLOW_MISS = 8,
  parameter int FPM_SLOW_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             use_tracker,
  input  logic             ext_hit,
  input  logic             mem_edo,
  input  logic             bus_fast,
  output logic             busy,
  output logic             data_rdy,
  output logic             burst_done,
  output logic             hit_taken
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [ROW_W-1:0]  open_row;
  logic              row_valid;
  logic [CNT_W-1:0]  cnt, gap_q, first_lat, gap_lat;
  logic [BEAT_W-1:0] beat;

  wire accept  = req_valid && !busy;
  wire hit_now = use_tracker ? (row_valid && req_row == open_row) : ext_hit;

  always_comb begin
    if (mem_edo) begin
      first_lat = hit_now ? CNT_W'(EDO_HIT) : CNT_W'(EDO_MISS);
      gap_lat   = CNT_W'(EDO_GAP);
    end else if (bus_fast) begin
      first_lat = hit_now ? CNT_W'(FPM_FAST_HIT) : CNT_W'(FPM_FAST_MISS);
      gap_lat   = CNT_W'(FPM_FAST_GAP);
    end else begin
      first_lat = hit_now ? CNT_W'(FPM_SLOW_HIT) : CNT_W'(FPM_SLOW_MISS);
      gap_lat   = CNT_W'(FPM_SLOW_GAP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row  <= '0;
      row_valid <= 1'b0;
      hit_taken <= 1'b0;
    end else if (accept) begin
      open_row  <= req_row;
      row_valid <= 1'b1;
      hit_taken <= hit_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      gap_q      <= '0;
      beat       <= '0;
      data_rdy   <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      data_rdy   <= 1'b0;
      burst_done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= first_lat - ONE;
        gap_q <= gap_lat;
        beat  <= '0;
      end else if (busy) begin
        if (cnt == '0) begin
          data_rdy <= 1'b1;
          cnt      <= gap_q - ONE;
          if (beat == LAST) begin
            burst_done <= 1'b1;
            busy       <= 1'b0;
            beat       <= '0;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/dram_burst_seq_chk.sv
module dram_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic data_rdy,
  input logic burst_done
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  // R5
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |=> !data_rdy);
  // R5
  done_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> data_rdy);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !busy);
  // R6
  rdy_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> $past(busy));
endmodule

bind dram_burst_seq dram_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .busy(busy), .data_rdy(data_rdy), .burst_done(burst_done)
);

// File: tb/dram_burst_seq_bench.sv
`timescale 1ns/1ps
module dram_burst_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, use_tracker = 1'b0, ext_hit = 1'b0;
  logic mem_edo = 1'b0, bus_fast = 1'b0;
  logic [7:0] req_row = '0;
  logic busy, data_rdy, burst_done, hit_taken;
  int total = 0, bad = 0;
  logic [7:0] m_row = '0;
  logic m_valid = 1'b0;

  always #2.5 clk = ~clk;

  dram_burst_seq u_dram_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .use_tracker(use_tracker), .ext_hit(ext_hit), .mem_edo(mem_edo),
    .bus_fast(bus_fast), .busy(busy), .data_rdy(data_rdy),
    .burst_done(burst_done), .hit_taken(hit_taken)
  );

  task automatic check(input logic cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input logic edo, input logic fast);
    if (edo) return "R2";
    return fast ? "R3" : "R4";
  endfunction

  task automatic burst(input logic [7:0] row, input logic edo, input logic fast,
                       input logic trk, input logic xh, input logic poke);
    logic hit;
    int f, g, pulses;
    hit = trk ? (m_valid && m_row == row) : xh;
    f = edo ? (hit ? 7 : 10) : fast ? (hit ? 7 : 10) : (hit ? 6 : 8);
    g = edo ? 2 : fast ? 4 : 3;
    pulses = 0;
    req_row = row; mem_edo = edo; bus_fast = fast; use_tracker = trk; ext_hit = xh;
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    m_row = row; m_valid = 1'b1;
    check(busy === 1'b1, "R1", busy, 1);
    check(hit_taken === hit, trk ? "R7" : "R9", hit_taken, hit);
    for (int k = 1; k <= f + 3*g + 1; k++) begin
      if (poke && k == 2) begin
        req_valid = 1'b1; req_row = row ^ 8'h5a; mem_edo = ~edo; bus_fast = ~fast;
        use_tracker = 1'b0; ext_hit = ~hit;
      end
      @(posedge clk); @(negedge clk);
      if (poke && k == 2) req_valid = 1'b0;
      begin
        logic er, ed;
        er = (k == f) || (k == f+g) || (k == f+2*g) || (k == f+3*g);
        ed = (k == f+3*g);
        if (data_rdy) pulses++;
        check(data_rdy === er, poke ? "R6" : tag(edo, fast), data_rdy, er);
        check(burst_done === ed, "R5", burst_done, ed);
        check(busy === (k < f+3*g), "R5", busy, k < f+3*g);
      end
    end
    check(pulses == 4, "R5", pulses, 4);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && data_rdy === 1'b0 && burst_done === 1'b0, "R1", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: first tracked request is a miss even with row zero
    burst(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    check(hit_taken === 1'b0, "R8", hit_taken, 0);
    // R7: same row hits, other row misses
    burst(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    burst(8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    burst(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R2 R3 R4 R9: full sweep with external hit
    for (int c = 0; c < 8; c++)
      burst(8'(c + 16), c[2], c[1], 1'b0, c[0], 1'b0);
    // R6: mid-burst requests ignored, row kept
    burst(8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    burst(8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check(hit_taken === 1'b1, "R6", hit_taken, 1);
    burst(8'h42, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    burst(8'h42, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check(hit_taken === 1'b1, "R7", hit_taken, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule